// File: doc/BRIEF.md
# Serial-to-Packet Collection Bridge

This block takes bytes arriving on an asynchronous 8N1 serial line and gathers them into a packet buffer of fixed size. The buffer stands in for the FIFO of a bulk IN endpoint. A valid received byte causes exactly one single-byte move into the next buffer slot. When the slot count reaches the packet size (64 bytes by default), the mover stops. It raises a packet-ready flag and gives a one-cycle completion interrupt. It then waits until the endpoint side reports with a one-cycle pulse that the packet has left. That pulse clears the flag, rewinds the write position to slot zero and re-arms the mover.

While the mover is paused, the ready-to-send output is dropped so that the far sender holds off. Any byte that arrives anyway is discarded. A registered read port lets the endpoint logic drain the stored packet. A packet shorter than the full size is never handed off: its bytes stay in the buffer until enough bytes arrive to complete it.

Top module: `uart_pkt_bridge`

## Requirements
- R1: One bit lasts CLK_DIV clocks (default 1248). A frame is a low start bit, 8 data bits sent LSB first and a high stop bit, with no parity. Each bit is sampled at its middle.
- R2: A low pulse on `rxd` that is shorter than half a bit period is rejected at the half-bit check and stores no byte.
- R3: Each accepted byte is written to the next slot, counting up from slot 0, so the first byte after reset or after a re-arm is found at address 0.
- R4: The write of the last slot (PKT_BYTES-1) sets `pkt_ready` to 1 and drives `done_irq` high for exactly one cycle, in the same cycle that `pkt_ready` rises. While fewer than PKT_BYTES bytes are stored, `pkt_ready` stays 0.
- R5: While paused (`pkt_ready` = 1), completed bytes are discarded and the buffer contents are unchanged.
- R6: A `pkt_sent` pulse while paused clears `pkt_ready` and restarts collection at slot 0. A `pkt_sent` pulse while collecting has no effect.
- R7: A frame whose stop bit samples low is dropped, and the next good byte takes the slot that the dropped byte would have used.
- R8: `rts` is 1 while collecting and 0 while paused.
- R9: `rd_data` shows the content of slot `rd_addr` one cycle after a clock edge with `rd_en` = 1, and holds its value while `rd_en` = 0.
- R10: If a byte completes in the same cycle as a `pkt_sent` pulse that ends a pause, that byte is kept and is stored at slot 0.
- R11: After reset: `pkt_ready` = 0, `done_irq` = 0, `rts` = 1, and collection starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| pkt_sent | input | 1 | One-cycle pulse: the stored packet has been sent |
| rd_en | input | 1 | Read strobe for the buffer port |
| rd_addr | input | $clog2(PKT_BYTES) | Buffer slot to read |
| rd_data | output | 8 | Registered read data |
| pkt_ready | output | 1 | A full packet is waiting and the mover is paused |
| done_irq | output | 1 | One-cycle pulse when a packet completes |
| rts | output | 1 | 1 = the sender may transmit |

## Verification
Two functions can act in the same cycle: a byte completing in the receiver, and the `pkt_sent` pulse that re-arms a paused mover. The bench deliberately ignores `rts` and starts a frame while paused. It counts clocks from the falling start edge, through the two-flop synchronizer, the half-bit confirmation and nine full bits, so that its `pkt_sent` pulse falls in exactly the cycle in which the byte is handed to the mover. The result is judged through the read port (the new byte must be in slot 0), through `pkt_ready` and `rts`, and by a following byte that must land in slot 1.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx
  import uart_pkt_pkg::*;
#(
  parameter int CLK_DIV = 1248,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_data
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(DATA_W + 1);

  logic              sync1_q, sync2_q, prev_q;
  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              vld_q, vld_n, ferr_q, ferr_n;

  // Next-state logic: midpoint sampling, glitch rejection at half bit
  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    vld_n  = 1'b0;
    ferr_n = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (prev_q && !sync2_q) begin
          st_n  = RX_START;
          cnt_n = '0;
        end
      end
      RX_START: begin
        if (cnt_q == CNT_W'(HALF - 1)) begin
          cnt_n = '0;
          bit_n = '0;
          st_n  = sync2_q ? RX_IDLE : RX_DATA;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == CNT_W'(CLK_DIV - 1)) begin
          cnt_n = '0;
          sh_n  = {sync2_q, sh_q[DATA_W-1:1]};
          if (bit_q == BIT_W'(DATA_W - 1)) st_n = RX_STOP;
          else                             bit_n = bit_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt_q == CNT_W'(CLK_DIV - 1)) begin
          cnt_n = '0;
          st_n  = RX_IDLE;
          if (sync2_q) vld_n  = 1'b1;
          else         ferr_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      vld_q   <= vld_n;
      ferr_q  <= ferr_n;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_data = sh_q;

  assert_vld_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  assert_ferr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && ferr_q));
endmodule

// File: rtl/pkt_mover.sv
module pkt_mover #(
  parameter int PKT_BYTES = 64,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_vld,
  input  logic [DATA_W-1:0]            byte_data,
  input  logic                         pkt_sent,
  output logic                         wr_en,
  output logic [$clog2(PKT_BYTES)-1:0] wr_addr,
  output logic [DATA_W-1:0]            wr_data,
  output logic                         pkt_ready,
  output logic                         done_irq,
  output logic                         rts
);
  localparam int ADDR_W = $clog2(PKT_BYTES);
  localparam int PTR_W  = $clog2(PKT_BYTES + 1);

  logic             en_q, en_n;
  logic [PTR_W-1:0] ptr_q, ptr_n, base;
  logic             rdy_q, rdy_n, irq_q, irq_n;
  logic             rearm, accept;

  always_comb begin
    rearm  = pkt_sent && !en_q;
    accept = byte_vld && (en_q || rearm);
    base   = rearm ? '0 : ptr_q;
    en_n   = en_q;
    ptr_n  = ptr_q;
    rdy_n  = rdy_q;
    irq_n  = 1'b0;
    if (rearm) begin
      en_n  = 1'b1;
      rdy_n = 1'b0;
      ptr_n = '0;
    end
    if (accept) begin
      ptr_n = base + 1'b1;
      if (base == PTR_W'(PKT_BYTES - 1)) begin
        en_n  = 1'b0;
        rdy_n = 1'b1;
        irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      ptr_q <= '0;
      rdy_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      ptr_q <= ptr_n;
      rdy_q <= rdy_n;
      irq_q <= irq_n;
    end
  end

  assign wr_en     = accept;
  assign wr_addr   = base[ADDR_W-1:0];
  assign wr_data   = byte_data;
  assign pkt_ready = rdy_q;
  assign done_irq  = irq_q;
  assign rts       = en_q && (ptr_q != PTR_W'(PKT_BYTES));

  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_ready_with_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> irq_q);
  assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(PKT_BYTES));
  assert_paused_rts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> !rts);
  assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && rdy_q) |=> !rdy_q);
endmodule

// File: rtl/pkt_buffer.sv
module pkt_buffer #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/uart_pkt_bridge.sv
module uart_pkt_bridge #(
  parameter int CLK_DIV   = 1248,
  parameter int PKT_BYTES = 64,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rxd,
  input  logic                         pkt_sent,
  input  logic                         rd_en,
  input  logic [$clog2(PKT_BYTES)-1:0] rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         pkt_ready,
  output logic                         done_irq,
  output logic                         rts
);
  localparam int ADDR_W = $clog2(PKT_BYTES);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              byte_vld, wr_en;
  logic [DATA_W-1:0] byte_data, wr_data;
  logic [ADDR_W-1:0] wr_addr;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pkt_uart_rx #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .rxd(rxd),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  pkt_mover #(.PKT_BYTES(PKT_BYTES), .DATA_W(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_int_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .pkt_sent(pkt_sent), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pkt_ready(pkt_ready), .done_irq(done_irq), .rts(rts)
  );

  pkt_buffer #(.DEPTH(PKT_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/uart_pkt_bridge_tb.sv
module uart_pkt_bridge_tb;
  localparam int DIV  = 16;
  localparam int HALF = DIV / 2;
  localparam int PKT  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       pkt_sent = 1'b0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pkt_ready, done_irq, rts;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0, irq_run = 0, irq_maxw = 0;
  logic irq_q = 1'b0, rdy_q = 1'b0, rdy_without_irq = 1'b0;

  always #2 clk = ~clk;

  uart_pkt_bridge #(.CLK_DIV(DIV), .PKT_BYTES(PKT), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .pkt_sent(pkt_sent),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_ready(pkt_ready), .done_irq(done_irq), .rts(rts)
  );

  // {stop_ok, data}: stop_ok = 0 gives a framing error
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b0, 8'h3C}, {1'b1, 8'hFF},
    {1'b1, 8'h81}, {1'b0, 8'h7E}, {1'b1, 8'h5A}, {1'b1, 8'h01}
  };

  function automatic logic [7:0] fillb(input int i);
    return 8'(i * 29 + 7);
  endfunction

  // Output monitor for the interrupt pulse and its alignment with pkt_ready
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_irq && !irq_q) irq_cnt++;
      if (done_irq) irq_run++; else irq_run = 0;
      if (irq_run > irq_maxw) irq_maxw = irq_run;
      if (pkt_ready && !rdy_q && !done_irq) rdy_without_irq = 1'b1;
      irq_q = done_irq;
      rdy_q = pkt_ready;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop_ok);
    @(negedge clk) rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int ptr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 pkt_ready", 32'(pkt_ready), 0);
    chk("R11 done_irq", 32'(done_irq), 0);
    chk("R11 rts", 32'(rts), 1);

    // R2: short low glitch must not start a frame
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);

    // Vector table: R1/R3 good frames, R7 framing errors
    ptr = 0;
    foreach (VEC[v]) begin
      send_frame(VEC[v][7:0], VEC[v][8]);
      if (VEC[v][8]) begin
        rd(ptr, d);
        chk(ptr == 0 ? "R2 R1 R3 first byte at slot 0" : "R1 R3 R7 slot content",
            32'(d), 32'(VEC[v][7:0]));
        ptr++;
      end
    end

    // R6: pkt_sent while collecting is ignored
    @(negedge clk) pkt_sent = 1'b1;
    @(negedge clk) pkt_sent = 1'b0;
    send_frame(8'h33, 1'b1);
    rd(ptr, d);
    chk("R6 sent-while-collecting ignored", 32'(d), 32'h33);
    rd(0, d);
    chk("R6 slot 0 kept", 32'(d), 32'hA5);
    ptr++;

    // Fill to the last slot but one
    while (ptr < PKT - 1) begin
      send_frame(fillb(ptr), 1'b1);
      ptr++;
    end
    chk("R4 short packet not ready", 32'(pkt_ready), 0);
    chk("R8 rts while collecting", 32'(rts), 1);
    chk("R4 no irq before full", 32'(irq_cnt), 0);
    send_frame(fillb(PKT - 1), 1'b1);
    chk("R4 ready after full", 32'(pkt_ready), 1);
    chk("R4 one irq", 32'(irq_cnt), 1);
    chk("R4 irq one cycle wide", 32'(irq_maxw), 1);
    chk("R4 irq with ready rise", 32'(rdy_without_irq), 0);
    chk("R8 rts while paused", 32'(rts), 0);

    // R5: byte while paused is discarded
    send_frame(8'hEE, 1'b1);
    chk("R5 still paused", 32'(pkt_ready), 1);
    rd(0, d);
    chk("R5 slot 0 unchanged", 32'(d), 32'hA5);
    rd(PKT - 1, d);
    chk("R9 read last slot", 32'(d), 32'(fillb(PKT - 1)));
    // R9: hold while rd_en low
    @(negedge clk) rd_addr = 6'd0;
    repeat (2) @(negedge clk);
    chk("R9 hold without rd_en", 32'(rd_data), 32'(fillb(PKT - 1)));

    // R10: byte completes in the same cycle as pkt_sent
    fork
      send_frame(8'hC3, 1'b1);
      begin
        @(negedge clk);
        repeat (3 + HALF + 9 * DIV) @(posedge clk);
        @(negedge clk) pkt_sent = 1'b1;
        @(negedge clk) pkt_sent = 1'b0;
      end
    join
    chk("R6 ready cleared by pkt_sent", 32'(pkt_ready), 0);
    chk("R8 rts after rearm", 32'(rts), 1);
    rd(0, d);
    chk("R10 coincident byte in slot 0", 32'(d), 32'hC3);
    send_frame(8'h4D, 1'b1);
    rd(1, d);
    chk("R3 next byte in slot 1", 32'(d), 32'h4D);
    chk("R4 no extra irq", 32'(irq_cnt), 1);

    // R11: reset in mid-packet restarts at slot 0
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 rts after reset", 32'(rts), 1);
    send_frame(8'h96, 1'b1);
    rd(0, d);
    chk("R11 slot 0 after reset", 32'(d), 32'h96);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule